// File: doc/BRIEF.md
# Multi-Channel Waveform Phase Memory

This block stores the pulse-shape samples of an eight-channel waveform generator. Each channel owns 24 slots, and each slot holds one 7-bit two's complement sample. A host reaches the storage indirectly, through three byte-wide registers picked by a 2-bit select:

- **Locator register:** a packed pointer that names the channel and the phase slot.
- **Sample register:** a write stores the value at the pointed-to slot. A read returns what is stored there.
- **Fan-out register:** a mask that copies the last written sample into the pointed-to phase of every channel whose bit is set, all in the same cycle.

A downstream waveform player reads from the block through its own set of ports, one per channel. For each channel the player drives a phase index and receives that channel's stored sample on the same cycle. These player ports are purely combinational. They have no handshake and never stall, so no back-pressure rule applies. The host side uses plain write and read strobes, and the read data is combinational on the select.

There are two resets:

- **Power-up reset** (asynchronous, active low) clears everything.
- **Software reset** (synchronous) only returns the locator register to zero. The sample store and the held sample value survive it.

Top module: `wavephase_mem`

## Requirements
- R1: The locator register (select 0) resets to 00h under both resets. It holds the channel number in bits [7:5] and the phase index in bits [4:0], and it reads back exactly what was written.
- R2: Writing the sample register (select 1) stores wdata[6:0] in the slot given by the locator. A read of select 1 returns {1'b0, stored sample} for that slot.
- R3: Bit 7 of a sample write is discarded, and bit 7 of rdata always reads 0 for select 1. The extreme values 3Fh and 40h are kept unchanged.
- R4: When the locator phase is 24 to 31, a sample write changes no slot and a select-1 read returns 00h.
- R5: Writing the fan-out register (select 2) with mask bit n set copies the last written sample into channel n at the locator phase. Channels whose mask bit is clear are untouched, and nothing is written when the phase is 24 or more.
- R6: The fan-out register is a one-shot. Select 2 and the unused select 3 always read 00h, and a write to select 3 has no effect.
- R7: Software reset clears the locator register. It leaves every stored sample and the held sample value unchanged, so a later fan-out still copies the old value.
- R8: Power-up reset clears every slot and the held sample value to zero.
- R9: Player port n returns channel n's sample for its index in the same cycle, returns 00h for indices 24 to 31, and stays stable while no host write occurs and its index is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| sw_rst | input | 1 | Synchronous software reset |
| reg_wr | input | 1 | Host write strobe |
| reg_sel | input | 2 | Register select: 0 locator, 1 sample, 2 fan-out |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for reg_sel (combinational) |
| play_idx | input | 40 | Player phase index, 5 bits per channel, channel 0 in the low bits |
| play_sample | output | 56 | Player samples, 7 bits per channel, channel 0 in the low bits |

## Verification
The bench aims at the out-of-range phases 24 to 31, which share an address field with valid slots. A design that decoded the phase loosely would corrupt a neighbouring slot, or return stale data where 00h is expected. It drives fan-out masks with mixed bits and checks every player port after each one. A design that misrouted the mask would write the wrong channels or leave a set channel stale. It also issues a software reset between a sample write and a fan-out, which exposes a design that wiped the held value or the store.

// File: rtl/wpm_pkg.sv
package wpm_pkg;
  localparam int unsigned NUM_CH   = 8;
  localparam int unsigned NUM_PH   = 24;
  localparam int unsigned SAMP_W   = 7;
  localparam int unsigned HREG_W   = 8;

  typedef enum logic [1:0] {
    SEL_LOC   = 2'd0,
    SEL_SAMP  = 2'd1,
    SEL_FAN   = 2'd2,
    SEL_SPARE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wpm_lane.sv
module wpm_lane #(
  parameter int unsigned DEPTH  = 24,
  parameter int unsigned SW     = 7,
  parameter int unsigned IDX_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [SW-1:0]    w_val,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [SW-1:0]    ra_val,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [SW-1:0]    rb_val
);
  logic [SW-1:0] slot_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) slot_q[i] <= '0;
    end else if (we && (32'(w_idx) < DEPTH)) begin
      slot_q[w_idx] <= w_val;
    end
  end

  always_comb begin
    ra_val = '0;
    rb_val = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (32'(ra_idx) == 32'(i)) ra_val = slot_q[i];
      if (32'(rb_idx) == 32'(i)) rb_val = slot_q[i];
    end
  end
endmodule

// File: rtl/wpm_regs.sv
module wpm_regs
  import wpm_pkg::*;
#(
  parameter int unsigned CH    = 8,
  parameter int unsigned SW    = 7,
  parameter int unsigned RW    = 8,
  parameter int unsigned CH_W  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] loc_q,
  output logic [SW-1:0] held_q,
  output logic [CH-1:0] lane_we,
  output logic [SW-1:0] lane_val
);
  logic [CH_W-1:0] tgt_ch;
  logic            wr_samp, wr_fan;

  assign tgt_ch  = loc_q[RW-1 -: CH_W];
  assign wr_samp = reg_wr && (reg_sel == SEL_SAMP);
  assign wr_fan  = reg_wr && (reg_sel == SEL_FAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              loc_q <= '0;
    else if (sw_rst)                         loc_q <= '0;
    else if (reg_wr && reg_sel == SEL_LOC)   loc_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (wr_samp) held_q <= wdata[SW-1:0];
  end

  assign lane_val = wr_samp ? wdata[SW-1:0] : held_q;

  for (genvar n = 0; n < int'(CH); n++) begin : g_we
    assign lane_we[n] = (wr_samp && (32'(tgt_ch) == 32'(n))) ||
                        (wr_fan && wdata[n]);
  end
endmodule

// File: rtl/wavephase_mem.sv
module wavephase_mem
  import wpm_pkg::*;
#(
  parameter int unsigned CH    = NUM_CH,
  parameter int unsigned DEPTH = NUM_PH,
  parameter int unsigned SW    = SAMP_W,
  parameter int unsigned RW    = HREG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [RW-1:0]    wdata,
  output logic [RW-1:0]    rdata,
  input  logic [CH*(RW-$clog2(CH))-1:0] play_idx,
  output logic [CH*SW-1:0] play_sample
);
  localparam int unsigned CH_W = $clog2(CH);
  localparam int unsigned PH_W = RW - CH_W;

  logic [RW-1:0]   loc_q;
  logic [SW-1:0]   held_q;
  logic [CH-1:0]   lane_we;
  logic [SW-1:0]   lane_val;
  logic [SW-1:0]   host_rd [CH];
  logic [PH_W-1:0] loc_ph;
  logic [CH_W-1:0] loc_ch;

  assign loc_ph = loc_q[PH_W-1:0];
  assign loc_ch = loc_q[RW-1 -: CH_W];

  wpm_regs #(.CH(CH), .SW(SW), .RW(RW), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .wdata(wdata), .loc_q(loc_q), .held_q(held_q),
    .lane_we(lane_we), .lane_val(lane_val)
  );

  for (genvar n = 0; n < int'(CH); n++) begin : g_lane
    wpm_lane #(.DEPTH(DEPTH), .SW(SW), .IDX_W(PH_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .we(lane_we[n]), .w_idx(loc_ph),
      .w_val(lane_val), .ra_idx(loc_ph), .ra_val(host_rd[n]),
      .rb_idx(play_idx[n*PH_W +: PH_W]),
      .rb_val(play_sample[n*SW +: SW])
    );
  end

  always_comb begin
    rdata = '0;
    unique case (reg_sel)
      SEL_LOC:  rdata = loc_q;
      SEL_SAMP: rdata = {{(RW-SW){1'b0}}, host_rd[loc_ch]};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/wpm_checker.sv
module wpm_checker #(
  parameter int unsigned CH   = 8,
  parameter int unsigned SW   = 7,
  parameter int unsigned RW   = 8,
  parameter int unsigned PH_W = 5,
  parameter int unsigned DEPTH = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_rst,
  input logic             reg_wr,
  input logic [1:0]       reg_sel,
  input logic [RW-1:0]    rdata,
  input logic [CH*PH_W-1:0] play_idx,
  input logic [CH*SW-1:0] play_sample,
  input logic [RW-1:0]    loc_q
);
  a_r3_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd1) |-> (rdata[RW-1] == 1'b0));

  a_r6_oneshot_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel[1] == 1'b1) |-> (rdata == '0));

  a_r7_sw_clears_locator: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (loc_q == '0));

  a_r9_stable_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_wr) && $stable(play_idx)) |-> $stable(play_sample));

  for (genvar n = 0; n < int'(CH); n++) begin : g_rng
    a_r4_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(play_idx[n*PH_W +: PH_W]) >= DEPTH) |-> (play_sample[n*SW +: SW] == '0));
  end
endmodule

bind wavephase_mem wpm_checker #(
  .CH(CH), .SW(SW), .RW(RW), .PH_W(PH_W), .DEPTH(DEPTH)
) u_wpm_checker (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .reg_wr(reg_wr),
  .reg_sel(reg_sel), .rdata(rdata), .play_idx(play_idx),
  .play_sample(play_sample), .loc_q(loc_q)
);

// File: tb/test_wavephase_mem.sv
module test_wavephase_mem;
  localparam int CYC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_rst = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [7:0]  wdata = 8'd0;
  logic [7:0]  rdata;
  logic [39:0] play_idx = '0;
  logic [55:0] play_sample;

  int vectors = 0;
  int fails   = 0;
  int stepno  = 0;

  int m_mem [8][24];
  int m_loc;
  int m_held;

  always #(CYC/2) clk = ~clk;

  wavephase_mem i_wavephase_mem (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata),
    .play_idx(play_idx), .play_sample(play_sample)
  );

  task automatic model_clear();
    for (int c = 0; c < 8; c++)
      for (int p = 0; p < 24; p++) m_mem[c][p] = 0;
    m_loc  = 0;
    m_held = 0;
  endtask

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h (step %0d)", req, what, act, exp, stepno);
    end
  endtask

  task automatic compare(string req);
    int ph, ch, exp;
    ph = m_loc & 31;
    ch = (m_loc >> 5) & 7;
    case (reg_sel)
      2'd0: exp = m_loc;
      2'd1: exp = (ph < 24) ? m_mem[ch][ph] : 0;
      default: exp = 0;
    endcase
    check(req, "rdata", int'(rdata), exp);
    for (int n = 0; n < 8; n++) begin
      int ix;
      ix = int'(play_idx[n*5 +: 5]);
      check("R9", $sformatf("play ch%0d idx%0d", n, ix),
            int'(play_sample[n*7 +: 7]), (ix < 24) ? m_mem[n][ix] : 0);
    end
  endtask

  task automatic step(bit wr, int sel, int d, bit sw, string req);
    @(negedge clk);
    stepno++;
    reg_wr  = wr;
    reg_sel = 2'(sel);
    wdata   = 8'(d);
    sw_rst  = sw;
    for (int n = 0; n < 8; n++) play_idx[n*5 +: 5] = 5'((stepno * 5 + n * 3) % 32);
    @(posedge clk);
    if (sw) m_loc = 0;
    else if (wr) begin
      int ph;
      ph = m_loc & 31;
      case (sel)
        0: m_loc = d & 255;
        1: begin
          m_held = d & 127;
          if (ph < 24) m_mem[(m_loc >> 5) & 7][ph] = d & 127;
        end
        2: for (int n = 0; n < 8; n++)
             if (((d >> n) & 1) == 1 && ph < 24) m_mem[n][ph] = m_held;
        default: ;
      endcase
    end
    #2;
    compare(req);
  endtask

  initial begin
    #(CYC * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 and R8: reset state
    step(0, 0, 0, 0, "R1");
    step(0, 1, 0, 0, "R8");
    step(0, 2, 0, 0, "R6");
    // R1: locator readback, channel 1 phase 3
    step(1, 0, 8'h23, 0, "R1");
    // R2 / R3: extremes and dropped bit 7
    step(1, 1, 8'h3F, 0, "R2");
    step(0, 1, 0, 0, "R2");
    step(1, 0, 8'h24, 0, "R1");
    step(1, 1, 8'hC0, 0, "R3");
    step(0, 1, 0, 0, "R3");
    // R4: channel 7 phase 29
    step(1, 0, 8'hFD, 0, "R1");
    step(1, 1, 8'h15, 0, "R4");
    step(0, 1, 0, 0, "R4");
    // R5: fan-out at channel 5 phase 23
    step(1, 0, 8'hB7, 0, "R1");
    step(1, 1, 8'h2A, 0, "R2");
    step(1, 2, 8'hA5, 0, "R5");
    step(0, 2, 0, 0, "R6");
    step(1, 3, 8'hFF, 0, "R6");
    // R5 with out-of-range phase writes nothing
    step(1, 0, 8'h1E, 0, "R1");
    step(1, 2, 8'hFF, 0, "R5");
    // R7: software reset keeps store and held value
    step(1, 0, 8'h49, 0, "R1");
    step(1, 1, 8'h55, 0, "R2");
    step(0, 0, 0, 1, "R7");
    step(0, 1, 0, 0, "R7");
    step(1, 0, 8'h06, 0, "R1");
    step(1, 2, 8'h0F, 0, "R7");
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) step(0, 0, 0, 1, "R7");
      else step(r < 12, int'($urandom % 4), int'($urandom % 256), 0, "R5");
    end
    // R8: power-up reset mid-run
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    model_clear();
    step(0, 1, 0, 0, "R8");
    step(0, 0, 0, 0, "R8");
    for (int k = 0; k < 6; k++) step(0, 1, 0, 0, "R8");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule